// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of a successive approximation analog-to-digital converter. It presents a registered N-bit trial code to an external DAC and reads one comparator bit back. A start request begins a binary search from the top bit downward. Each clock settles the bit under test from the comparator and tentatively raises the next lower bit, so every conversion takes exactly N clocks, whatever the input level.

In the comparator convention used here, `comp_in` low means the analog input is above the DAC output, so the bit under test is kept. `comp_in` high means the trial code is too large, so that bit is dropped. When the least significant bit has been settled, the controller pulses `done` for one cycle and latches the final code on `result`. `result` then holds that code until the next conversion completes. A start request that arrives while a conversion is running is ignored.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, `trial` and `result` are all zeros, `done` is low and the controller is idle.
- R2: A `start` sampled high at a rising edge while idle makes `trial` equal to only the top bit set (1000 for N=4) after that edge.
- R3: At each decision edge where `comp_in` is low, the bit under test stays set in `trial`, and the next lower bit is set if one exists.
- R4: At each decision edge where `comp_in` is high, the bit under test is cleared in `trial`, and the next lower bit is set if one exists.
- R5: The least significant bit is settled by `comp_in` in the same way as the others, and no further trial bit is raised after it.
- R6: `done` rises exactly N rising edges after the edge that accepted `start`.
- R7: `done` is high for exactly one cycle. In that cycle `result` equals the final settled code, and `trial` shows the same code.
- R8: `result` changes only at the completion edge. A `start` that is high while a conversion is in progress has no effect on the trial sequence or on the timing.
- R9: With a comparator that reads high exactly when the trial code exceeds an integer input level V (0 to 2^N-1), the final result equals V. For N=4 and V=9, the trial sequence is 1000, 1100, 1010, 1001 and the result is 1001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| comp_in | input | 1 | Comparator bit: high means the trial code is too large |
| trial | output | N | Registered code driven to the DAC |
| result | output | N | Last completed conversion code |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the embedded properties check several things: the top-bit load after an accepted start, the keep-or-clear effect of the comparator on the bit under test, the one-hot bit pointer, the single-cycle `done` pulse, and that `result` stays still outside completion. Some behaviours can only be shown by the bench's scenarios, which drive a behavioural comparator model. These are the end-to-end correctness of the search for arbitrary input levels (including 0 and full scale), the exact N-clock latency, and that a mid-conversion start leaves both the sequence and the timing untouched.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_seq.sv
// Sequencer: idle/busy state, one-hot pointer to the bit under test, done pulse.
module sar_seq
  import sar_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         load,
  output logic         busy,
  output logic         fin,
  output logic [N-1:0] ptr,
  output logic         done
);
  localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

  sar_state_e  state_q, state_d;
  logic [N-1:0] ptr_q, ptr_d;
  logic         done_q, done_d;

  assign busy = (state_q == ST_BUSY);
  assign load = (state_q == ST_IDLE) && start;
  assign fin  = busy && ptr_q[0];

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    done_d  = 1'b0;
    if (load) begin
      state_d = ST_BUSY;
      ptr_d   = TOP;
    end else if (busy) begin
      ptr_d = ptr_q >> 1;
      if (fin) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      done_q  <= done_d;
    end
  end

  assign ptr  = ptr_q;
  assign done = done_q;

  // R7: completion indication lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: pointer never holds more than one bit
  a_r5_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q));
  // R5: deciding the LSB ends the conversion next edge
  a_r5_lsb_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ptr_q[0]) |=> (done && state_q == ST_IDLE));
  // R8: a start while busy does not reload the pointer
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ptr_q[0] && start) |=> (ptr_q == ($past(ptr_q) >> 1)));
endmodule

// File: rtl/sar_datapath.sv
// Trial and result registers.
module sar_datapath #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         busy,
  input  logic         fin,
  input  logic [N-1:0] ptr,
  input  logic         comp_in,
  output logic [N-1:0] trial,
  output logic [N-1:0] result
);
  localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] trial_q, trial_d;
  logic [N-1:0] result_q;
  logic [N-1:0] settled;
  logic         trial_en, result_en;

  // Bit under test dropped when the comparator says "too large".
  assign settled   = comp_in ? (trial_q & ~ptr) : trial_q;
  assign trial_en  = load || busy;
  assign result_en = fin;

  always_comb begin
    trial_d = trial_q;
    if (load)      trial_d = TOP;
    else if (busy) trial_d = settled | (ptr >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trial_q <= '0;
    else if (trial_en) trial_q <= trial_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result_q <= '0;
    else if (result_en) result_q <= settled;
  end

  assign trial  = trial_q;
  assign result = result_q;

  // R2: accepted start loads the top bit alone
  a_r2_load_top: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (trial == TOP));
  // R3: comparator low keeps the bit under test
  a_r3_keep_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !comp_in) |=> ((trial & $past(ptr)) == $past(ptr)));
  // R4: comparator high clears the bit under test
  a_r4_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && comp_in) |=> ((trial & $past(ptr)) == '0));
  // R8: result only moves on the completion edge
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(result));
  // R7: completed result matches the final trial code
  a_r7_result_match: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (result == trial));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         comp_in,
  output logic [N-1:0] trial,
  output logic [N-1:0] result,
  output logic         done
);
  logic         load, busy, fin;
  logic [N-1:0] ptr;

  sar_seq #(.N(N)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .busy  (busy),
    .fin   (fin),
    .ptr   (ptr),
    .done  (done)
  );

  sar_datapath #(.N(N)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .busy    (busy),
    .fin     (fin),
    .ptr     (ptr),
    .comp_in (comp_in),
    .trial   (trial),
    .result  (result)
  );

  // R1: idle outputs quiet while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (trial == '0 && result == '0 && !done));
endmodule

// File: tb/sar_ctrl_bench.sv
module sar_ctrl_bench;
  localparam int N = 4;
  localparam int FULL = (1 << N) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         comp_in;
  logic [N-1:0] trial, result;
  logic         done;
  int           vin = 0;
  int           n_tests = 0;
  int           n_fail = 0;

  always #5 clk = ~clk;

  // Behavioural comparator: high when the DAC code exceeds the input level.
  assign comp_in = (int'(trial) > vin);

  sar_ctrl #(.N(N)) u_sar_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .comp_in(comp_in),
    .trial(trial), .result(result), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Trial code visible after decision step k (k=0 is the load).
  function automatic int exp_trial(input int level, input int k);
    int code = 0;
    for (int b = N - 1; b > N - 1 - k; b--) begin
      code |= (1 << b);
      if (code > level) code &= ~(1 << b);
    end
    if (k < N) code |= (1 << (N - 1 - k));
    return code;
  endfunction

  task automatic convert(input int level, input bit poke);
    int prev = int'(result);
    @(negedge clk);
    vin = level;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 top bit load", int'(trial), 1 << (N - 1));
    check("R6 no early done", int'(done), 0);
    for (int k = 1; k < N; k++) begin
      if (poke && k == 1) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check((int'(trial) & (1 << (N - k))) != 0 ? "R3 keep step" : "R4 clear step",
            int'(trial), exp_trial(level, k));
      check("R8 result held mid-conversion", int'(result), prev);
      check("R6 no early done", int'(done), 0);
    end
    @(negedge clk);
    check("R6 done after N edges", int'(done), 1);
    check("R9 final result", int'(result), level);
    check("R5 trial settles at LSB", int'(trial), exp_trial(level, N));
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
    check("R8 result held after done", int'(result), level);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trial reset", int'(trial), 0);
    check("R1 result reset", int'(result), 0);
    check("R1 done reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle without start", int'(trial), 0);

    // R9 worked case: level 9 gives 1000,1100,1010,1001
    convert(9, 1'b0);
    convert(0, 1'b0);
    convert(FULL, 1'b0);
    convert(8, 1'b1);   // R8 start during conversion
    convert(7, 1'b0);
    repeat (4) @(negedge clk);
    check("R8 result held while idle", int'(result), 7);

    void'($urandom(32'd1234));
    for (int i = 0; i < 40; i++) begin
      convert(int'($urandom % (FULL + 1)), ($urandom % 3) == 0);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule